// File: doc/BRIEF.md
# Carry-less Multiplier with Reversed and High-Half Modes

This block multiplies two 32-bit words as polynomials over GF(2): partial products are combined with XOR instead of addition, so no carries propagate. It is purely combinational: the result follows the operands and the mode select in the same cycle, with no register anywhere inside.

Three results can be selected. The low mode returns the lower 32 bits of the 63-bit product. The reversed mode returns product bits 62 down to 31. The high mode returns product bits 63 down to 32. The block never builds a 64-bit product. A single array of 32 partial-product rows, reduced by a 32-bit-wide XOR tree, serves every mode. For the reversed and high modes, both operands are bit-reversed on the way into the tree and the tree output is bit-reversed on the way out. The high result is the reversed result moved down by one bit.

The block has no streaming data path, so it has no valid/ready handshake. The operands are held stable, and the result is read in the same cycle.

Top module: `clmul_rev_top`

## Requirements
- R1: Each partial-product row k equals `op_a` shifted left by k positions when bit k of `op_b` is 1, and zero otherwise. In the low mode, `op_b` = 1<<k therefore gives `op_a` << k.
- R2: With `mode` = 2'b00 (low), `result` equals bits 31..0 of the carry-less product of `op_a` and `op_b`.
- R3: With `mode` = 2'b01 (reversed), `result` equals bits 62..31 of the carry-less product, with product bit 31 at `result` bit 0.
- R4: With `mode` = 2'b10 (high), `result` equals bits 63..32 of the carry-less product, so `result` bit 31 is always 0.
- R5: With `mode` = 2'b11, `result` is identical to the low-mode result.
- R6: If either operand is zero, `result` is zero in every mode.
- R7: Swapping `op_a` and `op_b` leaves `result` unchanged in every mode.
- R8: The operands 4'b1101 and 4'b1011, zero-extended, give 7'b1111111 in the low mode and zero in the reversed and high modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First polynomial operand |
| op_b | input | 32 | Second polynomial operand; its bit k enables partial-product row k |
| mode | input | 2 | 00 low, 01 reversed, 10 high, 11 low |
| result | output | 32 | Selected 32-bit slice of the carry-less product |

## Verification
The block holds no state, so a fault in a partial-product row, a tree node or a reversal stage shows on `result` in the same cycle as the operands that exercise it. A dropped row appears only when the matching bit of `op_b` is set, so single-bit operands are used to isolate each row. A faulty reversal wire corrupts only the reversed and high modes, at mirrored bit positions. Comparing the low and high results of the same operands against a full-width reference separates faults in the tree from faults in the output selection.

// File: rtl/clmul_rev_pkg.sv
package clmul_rev_pkg;
  typedef enum logic [1:0] {
    CLM_LOW     = 2'b00,
    CLM_REV     = 2'b01,
    CLM_HIGH    = 2'b10,
    CLM_LOW_ALT = 2'b11
  } clm_mode_e;
endpackage

// File: rtl/clmul_bit_rev.sv
module clmul_bit_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_swap
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/clmul_pp_array.sv
module clmul_pp_array #(
  parameter int W = 32
) (
  input  logic [W-1:0]        mcand,
  input  logic [W-1:0]        mplier,
  output logic [W-1:0][W-1:0] rows
);
  // row k: multiplicand moved up k places, gated by multiplier bit k
  for (genvar k = 0; k < W; k++) begin : g_row
    assign rows[k] = mplier[k] ? (mcand << k) : '0;
  end
endmodule

// File: rtl/clmul_xor_tree.sv
module clmul_xor_tree #(
  parameter int W = 32
) (
  input  logic [W-1:0][W-1:0] rows,
  output logic [W-1:0]        sum
);
  // heap-ordered binary tree: leaves at W-1 .. 2W-2, root at 0
  localparam int NODES = 2 * W - 1;
  localparam int INNER = W - 1;

  logic [W-1:0] node [NODES];

  for (genvar j = 0; j < W; j++) begin : g_leaf
    assign node[INNER + j] = rows[j];
  end

  for (genvar n = 0; n < INNER; n++) begin : g_inner
    assign node[n] = node[2*n+1] ^ node[2*n+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/clmul_rev_top.sv
module clmul_rev_top #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   mode,
  output logic [W-1:0] result
);
  import clmul_rev_pkg::*;

  clm_mode_e    sel;
  logic         flip;
  logic [W-1:0] a_rev, b_rev;
  logic [W-1:0] tree_a, tree_b;
  logic [W-1:0] tree_out, tree_out_rev;
  logic [W-1:0][W-1:0] rows;

  assign sel  = clm_mode_e'(mode);
  assign flip = (sel == CLM_REV) || (sel == CLM_HIGH);

  clmul_bit_rev #(.W(W)) u_rev_a (.din(op_a), .dout(a_rev));
  clmul_bit_rev #(.W(W)) u_rev_b (.din(op_b), .dout(b_rev));

  assign tree_a = flip ? a_rev : op_a;
  assign tree_b = flip ? b_rev : op_b;

  clmul_pp_array #(.W(W)) u_pp   (.mcand(tree_a), .mplier(tree_b), .rows(rows));
  clmul_xor_tree #(.W(W)) u_tree (.rows(rows), .sum(tree_out));
  clmul_bit_rev  #(.W(W)) u_rev_o(.din(tree_out), .dout(tree_out_rev));

  always_comb begin
    unique case (sel)
      CLM_REV:  result = tree_out_rev;
      CLM_HIGH: result = {1'b0, tree_out_rev[W-1:1]};
      default:  result = tree_out;
    endcase
  end

  // port-level checks on settled, known inputs
  always_comb begin
    if (!$isunknown({op_a, op_b, mode})) begin
      assert_high_msb_clear_R4: assert (mode != 2'b10 || result[W-1] == 1'b0);
      assert_zero_operand_R6: assert (!(op_a == '0 || op_b == '0) || result == '0);
      assert_unit_low_R2: assert (!(op_b == W'(1) && mode[0] == mode[1]) || result == op_a);
      assert_unit_rev_R3: assert (!(op_b == W'(1) && mode == 2'b01)
                                  || result == {{(W-1){1'b0}}, op_a[W-1]});
    end
  end
endmodule

// File: tb/tb_clmul_rev_top.sv
module tb_clmul_rev_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] op_a, op_b, result;
  logic [1:0]  mode;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  clmul_rev_top dut (.op_a(op_a), .op_b(op_b), .mode(mode), .result(result));

  // {mode, a, b, expected}
  localparam int NV = 10;
  localparam logic [97:0] VEC [NV] = '{
    {2'b00, 32'h0000000D, 32'h0000000B, 32'h0000007F},
    {2'b01, 32'h0000000D, 32'h0000000B, 32'h00000000},
    {2'b10, 32'h0000000D, 32'h0000000B, 32'h00000000},
    {2'b11, 32'h0000000D, 32'h0000000B, 32'h0000007F},
    {2'b00, 32'h80000000, 32'h80000000, 32'h00000000},
    {2'b01, 32'h80000000, 32'h80000000, 32'h80000000},
    {2'b10, 32'h80000000, 32'h80000000, 32'h40000000},
    {2'b00, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE},
    {2'b01, 32'hFFFFFFFF, 32'h00000002, 32'h00000003},
    {2'b10, 32'hFFFFFFFF, 32'h00000002, 32'h00000001}
  };

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p = '0;
    for (int k = 0; k < 32; k++) if (b[k]) p = p ^ ({32'h0, a} << k);
    return p;
  endfunction

  function automatic logic [31:0] ref_sel(input logic [1:0] m, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [63:0] p = ref_prod(a, b);
    case (m)
      2'b01:   return p[62:31];
      2'b10:   return p[63:32];
      default: return p[31:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    #1;
  endtask

  initial begin
    mode = 2'b00; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    #1 check("R6 reset zero inputs", result, 32'h0);
    rst = 1'b0;

    // table walk (R8 is entries 0-3)
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][97:96], VEC[v][95:64], VEC[v][63:32]);
      check("R2 R3 R4 R5 R8 table", result, VEC[v][31:0]);
    end

    // R1: single-bit multiplier selects one row
    for (int k = 0; k < 32; k++) begin
      apply(2'b00, 32'hA5C3_0F69, 32'h1 << k);
      check("R1 single row", result, 32'hA5C3_0F69 << k);
    end

    // R6: zero operands and all ones
    for (int m = 0; m < 4; m++) begin
      apply(2'(m), 32'hFFFFFFFF, 32'h0);
      check("R6 zero b", result, 32'h0);
      apply(2'(m), 32'h0, 32'hFFFFFFFF);
      check("R6 zero a", result, 32'h0);
      apply(2'(m), 32'hFFFFFFFF, 32'hFFFFFFFF);
      check("R2 R3 R4 R5 all ones", result, ref_sel(2'(m), 32'hFFFFFFFF, 32'hFFFFFFFF));
    end

    // random operands in every mode, plus R5 and R7
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b, r_low;
      a = $urandom; b = $urandom;
      apply(2'b00, a, b);
      check("R2 random low", result, ref_sel(2'b00, a, b));
      r_low = result;
      apply(2'b01, a, b);
      check("R3 random reversed", result, ref_sel(2'b01, a, b));
      apply(2'b10, a, b);
      check("R4 random high", result, ref_sel(2'b10, a, b));
      apply(2'b11, a, b);
      check("R5 mode 11 equals low", result, r_low);
      apply(2'(n % 3), b, a);
      check("R7 swapped operands", result, ref_sel(2'(n % 3), a, b));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule